// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Sequencer

This block is the part of a DRAM controller that owns every cycle that carries no data to an asynchronous EDO DRAM. After reset it waits out a long power-up pause. It then runs a fixed number of wake-up RAS cycles and raises `ready_o`. From then on it issues one CAS-before-RAS (CBR) refresh cycle every refresh interval. A companion access sequencer does the reads and writes.

The two sequencers share the DRAM strobes through a request/grant pair. The refresh sequencer raises `bus_req_o` and waits for `bus_gnt_i`. It drives the strobes while `strb_en_o` is high, and it keeps the request until the RAS precharge that follows its cycle has ended. Refresh intervals that expire while the grant is withheld are counted and issued later. If too many pile up, the rows are taken to be lost: `ready_o` drops and the wake-up burst is repeated. A self-refresh mode is entered by stretching a CBR cycle while `self_req_i` is high, and is left through a full RAS precharge.

All timing limits are parameters in nanoseconds, together with the clock period in picoseconds. Each limit is rounded up to whole clock cycles when the design is elaborated. During a CBR cycle the address pins are not used and the data pins stay released, so the block drives neither.

Top module: `dram_refresh_seq`

## Requirements
- R1: Each timing limit becomes ceil(limit_ns*1000/CLK_PS) clock cycles, with a minimum of 1. With a 5000 ps clock, a 7 ns CAS setup gives 2 cycles.
- R2: After reset is released, `ras_n_o` stays high and `ready_o` stays low for at least the pause count. Then exactly WAKE_CYCLES RAS cycles run, after which `ready_o` goes high.
- R3: In every cycle, `lcas_n_o` and `ucas_n_o` both fall together. RAS falls exactly the CAS-setup count later. Both CAS strobes stay low for the whole time RAS is low and rise when RAS rises.
- R4: `we_n_o` and `oe_n_o` are high at all times.
- R5: In a plain refresh, RAS is low for exactly the RAS-width count. RAS is never low again until it has been high for at least the precharge count.
- R6: No strobe moves until a grant has been seen. After RAS rises, `bus_req_o` stays high for exactly the precharge count and then drops.
- R7: While ready, one refresh is due per refresh interval. Intervals that expire while the grant is withheld are all issued once the grant returns.
- R8: When more than PEND_MAX refreshes are owed, `ready_o` falls. WAKE_CYCLES wake-up cycles then run, without the power-up pause, before `ready_o` rises again.
- R9: If `self_req_i` is high when a refresh's RAS width ends, RAS stays low and `self_active_o` is high. This lasts until `self_req_i` is low and at least the self-refresh minimum has passed, so the shortest total RAS low time is the RAS width plus the self minimum. A precharge follows.
- R10: After self-refresh exits, no refresh debt remains. The next refresh comes one full interval later.
- R11: `strb_en_o` is high only while `bus_req_o` is high, and it is high whenever any strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_gnt_i | input | 1 | Grant from the access sequencer; held while `bus_req_o` is high |
| self_req_i | input | 1 | Level request to enter or stay in self-refresh |
| bus_req_o | output | 1 | Request for the DRAM strobes |
| strb_en_o | output | 1 | This block is driving the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower-byte column strobe, active low |
| ucas_n_o | output | 1 | Upper-byte column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| oe_n_o | output | 1 | Output enable, held high |
| ready_o | output | 1 | Wake-up complete; data access allowed |
| self_active_o | output | 1 | Self-refresh in progress |

## Verification
The bench uses a 5000 ps clock with a 2 µs pause, a 1 µs refresh interval, a 500 ns self-refresh minimum, a 7 ns CAS setup and PEND_MAX of 4. The pause becomes 400 cycles and the interval 200 cycles, so power-up, several refresh periods, a deferral deep enough to force a repeated wake-up, and both long and shortest self-refresh all fit in a short run. The 7 ns setup shows the round-up. RAS width (10 cycles) and precharge (6 cycles) keep their real values, so the strobe timing is checked at its true size.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    CY_IDLE = 3'd0,
    CY_REQ  = 3'd1,
    CY_CSR  = 3'd2,
    CY_RASL = 3'd3,
    CY_SELF = 3'd4,
    CY_RP   = 3'd5
  } cyc_state_t;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  // Round a time limit up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ps);
    longint unsigned num;
    longint unsigned q;
    num = 64'(t_ns) * 64'd1000;
    q   = (num + 64'(clk_ps) - 64'd1) / 64'(clk_ps);
    if (q == 64'd0) q = 64'd1;
    return 32'(q);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drs_interval.sv
module drs_interval #(
  parameter int unsigned N_REFI = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(N_REFI + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == CW'(N_REFI - 1));
  assign tick_o = en_i && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)      cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/drs_pending.sv
module drs_pending #(
  parameter int unsigned PEND_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic nonzero_o,
  output logic ovf_o,
  output logic [$clog2(PEND_MAX+1)-1:0] cnt_o
);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          full;
  logic          up, down;

  assign full      = (cnt_q == PW'(PEND_MAX));
  assign up        = inc_i && !dec_i;
  assign down      = dec_i && !inc_i && (cnt_q != '0);
  assign ovf_o     = up && full && !clr_i;
  assign nonzero_o = (cnt_q != '0);
  assign cnt_o     = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)               cnt_d = '0;
    else if (up && !full)    cnt_d = cnt_q + 1'b1;
    else if (down)           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_pend_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= PW'(PEND_MAX)));

  assert_ovf_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == PW'(PEND_MAX)) || $past(clr_i));

endmodule

// File: rtl/drs_cycle_fsm.sv
module drs_cycle_fsm
  import drs_pkg::*;
#(
  parameter int unsigned N_CSR  = 1,
  parameter int unsigned N_RAS  = 10,
  parameter int unsigned N_SELF = 20000,
  parameter int unsigned N_RP   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic gnt_i,
  input  logic self_req_i,
  input  logic self_ok_i,
  output logic req_o,
  output logic strb_en_o,
  output logic ras_n_o,
  output logic lcas_n_o,
  output logic ucas_n_o,
  output logic we_n_o,
  output logic oe_n_o,
  output logic done_o,
  output logic self_exit_o,
  output logic self_active_o
);
  localparam int unsigned CNT_TOP = max2(max2(N_CSR, N_RAS), max2(N_SELF, N_RP));
  localparam int CW = $clog2(CNT_TOP + 1);

  cyc_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          from_self_q, from_self_d;
  logic          csr_last, ras_last, self_min, rp_last;
  logic          cas_low;

  assign csr_last = (cnt_q == CW'(N_CSR - 1));
  assign ras_last = (cnt_q == CW'(N_RAS - 1));
  assign self_min = (cnt_q >= CW'(N_SELF - 1));
  assign rp_last  = (cnt_q == CW'(N_RP - 1));

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    from_self_d = from_self_q;
    case (state_q)
      CY_IDLE: begin
        cnt_d       = '0;
        from_self_d = 1'b0;
        if (start_i) state_d = CY_REQ;
      end
      CY_REQ: begin
        if (gnt_i) begin
          state_d = CY_CSR;
          cnt_d   = '0;
        end
      end
      CY_CSR: begin
        if (csr_last) begin
          state_d = CY_RASL;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CY_RASL: begin
        if (ras_last) begin
          cnt_d = '0;
          if (self_req_i && self_ok_i) begin
            state_d     = CY_SELF;
            from_self_d = 1'b1;
          end else begin
            state_d = CY_RP;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CY_SELF: begin
        if (self_min && !self_req_i) begin
          state_d = CY_RP;
          cnt_d   = '0;
        end else if (!self_min) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CY_RP: begin
        if (rp_last) begin
          state_d = CY_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = CY_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CY_IDLE;
      cnt_q       <= '0;
      from_self_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      from_self_q <= from_self_d;
    end
  end

  assign cas_low       = (state_q == CY_CSR) || (state_q == CY_RASL) || (state_q == CY_SELF);
  assign ras_n_o       = !((state_q == CY_RASL) || (state_q == CY_SELF));
  assign lcas_n_o      = !cas_low;
  assign ucas_n_o      = !cas_low;
  assign we_n_o        = 1'b1;
  assign oe_n_o        = 1'b1;
  assign req_o         = (state_q != CY_IDLE);
  assign strb_en_o     = cas_low || (state_q == CY_RP);
  assign done_o        = (state_q == CY_RP) && rp_last;
  assign self_exit_o   = done_o && from_self_q;
  assign self_active_o = (state_q == CY_SELF);

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (!lcas_n_o && !ucas_n_o && $past(!lcas_n_o) && $past(!ucas_n_o)));

  assert_cas_after_gnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcas_n_o && $past(lcas_n_o)) |-> $past(gnt_i));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int unsigned CLK_PS      = 5000,
  parameter int unsigned T_PAUSE_NS  = 200000,
  parameter int unsigned T_REFI_NS   = 15600,
  parameter int unsigned T_RAS_NS    = 50,
  parameter int unsigned T_RP_NS     = 30,
  parameter int unsigned T_CSR_NS    = 5,
  parameter int unsigned T_SELF_NS   = 100000,
  parameter int unsigned WAKE_CYCLES = 8,
  parameter int unsigned PEND_MAX    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt_i,
  input  logic self_req_i,
  output logic bus_req_o,
  output logic strb_en_o,
  output logic ras_n_o,
  output logic lcas_n_o,
  output logic ucas_n_o,
  output logic we_n_o,
  output logic oe_n_o,
  output logic ready_o,
  output logic self_active_o
);
  localparam int unsigned N_PAUSE = ns_to_cycles(T_PAUSE_NS, CLK_PS);
  localparam int unsigned N_REFI  = ns_to_cycles(T_REFI_NS, CLK_PS);
  localparam int unsigned N_RAS   = ns_to_cycles(T_RAS_NS, CLK_PS);
  localparam int unsigned N_RP    = ns_to_cycles(T_RP_NS, CLK_PS);
  localparam int unsigned N_CSR   = ns_to_cycles(T_CSR_NS, CLK_PS);
  localparam int unsigned N_SELF  = ns_to_cycles(T_SELF_NS, CLK_PS);
  localparam int PSW = $clog2(N_PAUSE + 1);
  localparam int WKW = $clog2(WAKE_CYCLES + 1);
  localparam int PDW = $clog2(PEND_MAX + 1);
  localparam int LOW = $clog2(N_RAS + 1);
  localparam int HIW = $clog2(N_RP + 1);

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  phase_t         phase_q, phase_d;
  logic [PSW-1:0] pause_q, pause_d;
  logic [WKW-1:0] wake_q, wake_d;
  logic           run;
  logic           start;
  logic           tick, done, self_exit, pend_nz, ovf;
  logic [PDW-1:0] pend_cnt;

  assign run = (phase_q == PH_RUN);

  always_comb begin
    phase_d = phase_q;
    pause_d = pause_q;
    wake_d  = wake_q;
    case (phase_q)
      PH_PAUSE: begin
        if (pause_q == PSW'(N_PAUSE - 1)) begin
          phase_d = PH_WAKE;
          pause_d = '0;
        end else begin
          pause_d = pause_q + 1'b1;
        end
      end
      PH_WAKE: begin
        if (done) begin
          if (wake_q == WKW'(WAKE_CYCLES - 1)) begin
            phase_d = PH_RUN;
            wake_d  = '0;
          end else begin
            wake_d = wake_q + 1'b1;
          end
        end
      end
      PH_RUN: begin
        if (ovf) begin
          phase_d = PH_WAKE;
          wake_d  = '0;
        end
      end
      default: phase_d = PH_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phase_q <= PH_PAUSE;
      pause_q <= '0;
      wake_q  <= '0;
    end else begin
      phase_q <= phase_d;
      pause_q <= pause_d;
      wake_q  <= wake_d;
    end
  end

  assign start   = (phase_q == PH_WAKE) || (run && (pend_nz || self_req_i));
  assign ready_o = run;

  drs_interval #(.N_REFI(N_REFI)) u_interval (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .en_i   (run && !self_active_o),
    .tick_o (tick)
  );

  drs_pending #(.PEND_MAX(PEND_MAX)) u_pending (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .inc_i     (tick),
    .dec_i     (done),
    .clr_i     (!run || self_exit),
    .nonzero_o (pend_nz),
    .ovf_o     (ovf),
    .cnt_o     (pend_cnt)
  );

  drs_cycle_fsm #(
    .N_CSR  (N_CSR),
    .N_RAS  (N_RAS),
    .N_SELF (N_SELF),
    .N_RP   (N_RP)
  ) u_cycle (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .start_i       (start),
    .gnt_i         (bus_gnt_i),
    .self_req_i    (self_req_i),
    .self_ok_i     (run),
    .req_o         (bus_req_o),
    .strb_en_o     (strb_en_o),
    .ras_n_o       (ras_n_o),
    .lcas_n_o      (lcas_n_o),
    .ucas_n_o      (ucas_n_o),
    .we_n_o        (we_n_o),
    .oe_n_o        (oe_n_o),
    .done_o        (done),
    .self_exit_o   (self_exit),
    .self_active_o (self_active_o)
  );

  // Strobe-width watch counters for the checks below.
  logic [LOW-1:0] low_run;
  logic [HIW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      low_run <= '0;
      hi_run  <= HIW'(N_RP);
    end else begin
      if (ras_n_o) low_run <= '0;
      else if (low_run != LOW'(N_RAS)) low_run <= low_run + 1'b1;
      if (!ras_n_o) hi_run <= '0;
      else if (hi_run != HIW'(N_RP)) hi_run <= hi_run + 1'b1;
    end
  end

  assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ras_n_o) |-> (low_run == LOW'(N_RAS)));

  assert_ras_precharge_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(ras_n_o) |-> (hi_run == HIW'(N_RP)));

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase_q == PH_PAUSE) |-> (ras_n_o && !bus_req_o));

  assert_debt_cleared_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ready_o |=> (pend_cnt == '0));

  assert_self_holds_ras_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    self_active_o |-> (!ras_n_o && bus_req_o && ready_o));

  assert_strobe_owner_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ras_n_o || !lcas_n_o || !ucas_n_o) |-> (strb_en_o && bus_req_o));

endmodule

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;

  localparam int RAS_CYC  = 10;
  localparam int RP_CYC   = 6;
  localparam int CSR_CYC  = 2;
  localparam int SELF_CYC = 100;
  localparam int PAUSE_CYC = 400;
  localparam int REFI_CYC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_gnt = 1'b0;
  logic self_req = 1'b0;
  logic bus_req, strb_en, ras_n, lcas_n, ucas_n, we_n, oe_n, ready, self_active;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .CLK_PS(5000), .T_PAUSE_NS(2000), .T_REFI_NS(1000), .T_RAS_NS(50),
    .T_RP_NS(30), .T_CSR_NS(7), .T_SELF_NS(500), .WAKE_CYCLES(8), .PEND_MAX(4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_gnt_i(bus_gnt), .self_req_i(self_req),
    .bus_req_o(bus_req), .strb_en_o(strb_en), .ras_n_o(ras_n),
    .lcas_n_o(lcas_n), .ucas_n_o(ucas_n), .we_n_o(we_n), .oe_n_o(oe_n),
    .ready_o(ready), .self_active_o(self_active)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  // Port monitors
  int falls = 0, low_len = 0, last_low = 0, cas_lead = 0, last_lead = 0;
  int tail = 0, last_tail = 0, hi_len = 0, min_hi = 1000000;
  bit tail_on = 1'b0, prev_ras = 1'b1;
  int bad_cas = 0, bad_weoe = 0, bad_strb = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        falls++;
        last_lead = cas_lead;
        low_len = 1;
        if (falls > 1 && hi_len < min_hi) min_hi = hi_len;
      end else if (!ras_n) low_len++;
      if (!prev_ras && ras_n) begin
        last_low = low_len;
        tail = bus_req ? 1 : 0;
        tail_on = 1'b1;
        hi_len = 1;
      end else if (ras_n) begin
        hi_len++;
        if (tail_on) begin
          if (bus_req) tail++;
          else begin
            last_tail = tail;
            tail_on = 1'b0;
          end
        end
      end
      if (ras_n && !lcas_n) cas_lead++;
      else if (lcas_n) cas_lead = 0;
      if ((!ras_n && (lcas_n || ucas_n)) || (lcas_n != ucas_n)) bad_cas++;
      if (!we_n || !oe_n) bad_weoe++;
      if (strb_en && !bus_req) bad_strb++;
      if ((!ras_n || !lcas_n || !ucas_n) && !strb_en) bad_strb++;
      prev_ras = ras_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req_low();
    for (int i = 0; i < 2000 && bus_req; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    wait_cyc(5);
    chk(ras_n && lcas_n && ucas_n, "R2", "strobes idle in reset", {29'd0, ras_n, lcas_n, ucas_n}, 7);
    chk(!ready && !bus_req && !strb_en, "R2", "ready/req low in reset", {29'd0, ready, bus_req, strb_en}, 0);
  endtask

  task automatic test_init();
    int t0;
    bus_gnt = 1'b1;
    rst_n = 1'b1;
    t0 = cyc;
    wait_cyc(300);
    chk(falls == 0 && !ready, "R2", "no RAS during pause", falls, 0);
    for (int i = 0; i < 1000 && falls == 0; i++) @(negedge clk);
    chk(cyc - t0 >= PAUSE_CYC, "R2", "pause length before first RAS", cyc - t0, PAUSE_CYC);
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
    chk(falls == 8, "R2", "wake-up RAS cycles before ready", falls, 8);
    wait_cyc(2);
    chk(last_lead == CSR_CYC, "R1", "CAS setup cycles (7ns rounded up)", last_lead, CSR_CYC);
    chk(last_low == RAS_CYC, "R5", "RAS low width", last_low, RAS_CYC);
    chk(last_tail == RP_CYC, "R6", "request held through precharge", last_tail, RP_CYC);
  endtask

  task automatic test_periodic();
    int f0;
    f0 = falls;
    wait_cyc(2000);
    chk(falls - f0 >= 9 && falls - f0 <= 11, "R7", "refreshes in 10 intervals", falls - f0, 10);
    chk(ready, "R7", "ready held in steady refresh", ready, 1);
  endtask

  task automatic test_defer();
    int f0;
    wait_req_low();
    bus_gnt = 1'b0;
    f0 = falls;
    wait_cyc(650);
    chk(falls == f0 && bus_req, "R6", "no RAS without grant", falls - f0, 0);
    chk(ready, "R7", "ready kept with owed refreshes", ready, 1);
    bus_gnt = 1'b1;
    wait_cyc(150);
    chk(falls - f0 >= 3 && falls - f0 <= 5, "R7", "deferred refreshes issued", falls - f0, 3);
  endtask

  task automatic test_overflow();
    int f0, t0;
    wait_req_low();
    bus_gnt = 1'b0;
    f0 = falls;
    wait_cyc(1300);
    chk(!ready, "R8", "ready drops after too many owed", ready, 0);
    chk(falls == f0, "R6", "no RAS while grant withheld", falls - f0, 0);
    bus_gnt = 1'b1;
    t0 = cyc;
    for (int i = 0; i < 1000 && !ready; i++) @(negedge clk);
    chk(falls - f0 == 8, "R8", "repeated wake-up cycles", falls - f0, 8);
    chk(cyc - t0 < 300, "R8", "no power-up pause on re-wake", cyc - t0, 200);
  endtask

  task automatic test_self_long();
    int f0;
    wait_req_low();
    self_req = 1'b1;
    for (int i = 0; i < 500 && !self_active; i++) @(negedge clk);
    chk(self_active, "R9", "self-refresh entered", self_active, 1);
    f0 = falls;
    wait_cyc(300);
    chk(!ras_n && self_active && falls == f0, "R9", "RAS held low in self-refresh", falls - f0, 0);
    self_req = 1'b0;
    wait_cyc(2);
    wait_req_low();
    wait_cyc(2);
    chk(last_low >= RAS_CYC + SELF_CYC, "R9", "self RAS low length", last_low, RAS_CYC + SELF_CYC);
    chk(last_tail == RP_CYC, "R9", "precharge after self exit", last_tail, RP_CYC);
    f0 = falls;
    wait_cyc(150);
    chk(falls == f0, "R10", "no catch-up burst after self exit", falls - f0, 0);
    wait_cyc(100);
    chk(falls == f0 + 1, "R10", "first refresh one interval after exit", falls - f0, 1);
  endtask

  task automatic test_self_short();
    wait_req_low();
    self_req = 1'b1;
    for (int i = 0; i < 500 && !self_active; i++) @(negedge clk);
    self_req = 1'b0;
    wait_cyc(2);
    wait_req_low();
    wait_cyc(2);
    chk(last_low == RAS_CYC + SELF_CYC, "R9", "shortest self RAS low", last_low, RAS_CYC + SELF_CYC);
    chk(ready, "R9", "ready after short self-refresh", ready, 1);
  endtask

  task automatic test_global();
    chk(bad_cas == 0, "R3", "CAS low throughout RAS low", bad_cas, 0);
    chk(bad_weoe == 0, "R4", "WE/OE never low", bad_weoe, 0);
    chk(min_hi >= RP_CYC, "R5", "minimum RAS precharge", min_hi, RP_CYC);
    chk(bad_strb == 0, "R11", "strobe enable tracks ownership", bad_strb, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    test_reset();
    test_init();
    test_periodic();
    test_defer();
    test_periodic();
    test_overflow();
    test_self_long();
    test_self_short();
    test_global();
    finish_run();
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

endmodule